// File: doc/BRIEF.md
# Address-Masked GPIO Port

An eight-pin general-purpose I/O port attached to an APB-style register bus. Software picks which pins a data access touches through address bits [9:2] of the access, not through the data. A single pin can therefore be set or cleared with one write, with no read-modify-write. Each pin has a direction bit. Output pins drive the stored output value onto their pad with the output enable asserted. Input pins are sampled through a two-flop synchroniser on the bus clock.

The synchronised pad inputs are also brought out on their own port, so that a neighbouring interrupt unit can use them. The bus never inserts wait states. Writes take effect on the clock edge of the access phase. Read data is driven combinationally during the access phase.

Top module: `gpio_masked_port`

## Requirements
- R1: After reset, the direction register reads 0x00, the stored output value is 0x00, `pad_oe_o` is 0x00 and `pad_out_o` is 0x00.
- R2: Offsets 0x000 to 0x3FC form the data window. Pin n of a data access is selected by address bit n+2, so offset 0x004 selects pin 0 and offset 0x200 selects pin 7.
- R3: A data write updates only the stored output bits whose pins are selected by the address and are in output mode. Every other stored output bit keeps its value.
- R4: A data read returns 0 on every unselected pin.
- R5: The direction register is at offset 0x400 exactly and can be both read and written. Bit n set to 1 makes pin n an output, and 0 makes it an input. `pad_oe_o` equals the direction register.
- R6: A data write has no effect on a pin in input mode. Output data for a pin is loaded only after the pin has been switched to output.
- R7: On a selected output pin, a data read returns the driven output value. On a selected input pin, it returns the pad input after two bus-clock flops. A pad change set up before edge k appears on `sync_in_o` and in read data after edge k+1.
- R8: Reads of any offset outside the data window and other than 0x400 return 0x00. Writes to such offsets change no state.
- R9: `pready_o` is always 1. A write completes on the clock edge at which `psel_i`, `penable_i` and `pwrite_i` are all high. Reads and idle cycles change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| psel_i | input | 1 | Peripheral select |
| penable_i | input | 1 | Access phase strobe |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | 12 | Byte offset of the access |
| pwdata_i | input | 8 | Write data |
| prdata_o | output | 8 | Read data, valid in the access phase |
| pready_o | output | 1 | Transfer complete, tied high |
| pad_in_i | input | 8 | Asynchronous pad inputs |
| pad_out_o | output | 8 | Output values to pads |
| pad_oe_o | output | 8 | Output enables to pads |
| sync_in_o | output | 8 | Synchronised pad inputs for an interrupt unit |

## Verification
The assertions take for granted that a write strobe lasts one access phase. They also assume that data and direction writes never fall in the same cycle, which the address decode guarantees. The synchroniser check further assumes that the pad inputs are known after reset.

The bench changes pad inputs and bus signals only on falling clock edges and always drives known values. Its bus tasks follow a strict setup-then-access sequence, so each write strobe is high for exactly one rising edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int NUM_PINS    = 8;
  localparam int ADDR_W      = 12;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_DATA = 2'd1,
    RGN_DIR  = 2'd2
  } region_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int CNT_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[0] <= '0;
          else         stg_q[0] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[s] <= '0;
          else         stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

  // Cycles since reset, saturating; gates the latency check
  logic [CNT_W-1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       age_q <= '0;
    else if (age_q != CNT_W'(STAGES))  age_q <= age_q + 1'b1;
  end

  p_sync_delay_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == CNT_W'(STAGES)) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int AW   = ADDR_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            psel_i,
  input  logic            penable_i,
  input  logic            pwrite_i,
  input  logic [AW-1:0]   paddr_i,
  input  logic [PINS-1:0] dir_i,
  input  logic [PINS-1:0] out_i,
  input  logic [PINS-1:0] sync_i,
  output logic            wr_data_o,
  output logic            wr_dir_o,
  output logic [PINS-1:0] mask_o,
  output logic [PINS-1:0] rdata_o
);
  localparam int          DIR_OFF = 1 << (PINS + 2);
  localparam logic [AW-1:0] DIR_A = AW'(DIR_OFF);

  region_e rgn;
  logic    access;

  always_comb begin
    if (paddr_i < DIR_A)       rgn = RGN_DATA;
    else if (paddr_i == DIR_A) rgn = RGN_DIR;
    else                       rgn = RGN_NONE;
  end

  assign access    = psel_i & penable_i;
  assign mask_o    = paddr_i[PINS+1:2];
  assign wr_data_o = access & pwrite_i & (rgn == RGN_DATA);
  assign wr_dir_o  = access & pwrite_i & (rgn == RGN_DIR);

  always_comb begin
    unique case (rgn)
      RGN_DATA: rdata_o = mask_o & ((dir_i & out_i) | (~dir_i & sync_i));
      RGN_DIR:  rdata_o = dir_i;
      default:  rdata_o = '0;
    endcase
  end

  p_unsel_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i < DIR_A) |-> ((rdata_o & ~paddr_i[PINS+1:2]) == '0));

  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (paddr_i > DIR_A) |-> (rdata_o == '0 && !wr_data_o && !wr_dir_o));

  p_one_target_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_data_o && wr_dir_o));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int PINS = NUM_PINS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_data_i,
  input  logic            wr_dir_i,
  input  logic [PINS-1:0] mask_i,
  input  logic [PINS-1:0] wdata_i,
  output logic [PINS-1:0] dir_o,
  output logic [PINS-1:0] out_o
);
  logic [PINS-1:0] dir_q, out_q, upd;

  // Only selected, output-mode pins accept data
  assign upd = mask_i & dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '0;
    else if (wr_dir_i) dir_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        out_q <= '0;
    else if (wr_data_i) out_q <= (out_q & ~upd) | (wdata_i & upd);
  end

  assign dir_o = dir_q;
  assign out_o = out_q;

  p_unsel_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (((out_q ^ $past(out_q)) & ~$past(mask_i)) == '0));

  p_sel_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (((out_q ^ $past(wdata_i)) & $past(mask_i & dir_q)) == '0));

  p_input_ignored_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data_i |=> (((out_q ^ $past(out_q)) & ~$past(dir_q)) == '0));

  p_out_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_data_i |=> $stable(out_q));

  p_dir_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_dir_i |=> $stable(dir_q));
endmodule

// File: rtl/gpio_masked_port.sv
module gpio_masked_port
  import gpio_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                psel_i,
  input  logic                penable_i,
  input  logic                pwrite_i,
  input  logic [ADDR_W-1:0]   paddr_i,
  input  logic [NUM_PINS-1:0] pwdata_i,
  output logic [NUM_PINS-1:0] prdata_o,
  output logic                pready_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] sync_in_o
);
  logic                wr_data, wr_dir;
  logic [NUM_PINS-1:0] mask, dir, outv, sync;

  gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_in_i),
    .q_o   (sync)
  );

  gpio_decode #(.PINS(NUM_PINS), .AW(ADDR_W)) u_decode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .dir_i    (dir),
    .out_i    (outv),
    .sync_i   (sync),
    .wr_data_o(wr_data),
    .wr_dir_o (wr_dir),
    .mask_o   (mask),
    .rdata_o  (prdata_o)
  );

  gpio_regs #(.PINS(NUM_PINS)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_data_i(wr_data),
    .wr_dir_i (wr_dir),
    .mask_i   (mask),
    .wdata_i  (pwdata_i),
    .dir_o    (dir),
    .out_o    (outv)
  );

  assign pready_o  = 1'b1;
  assign pad_oe_o  = dir;
  assign pad_out_o = outv;
  assign sync_in_o = sync;
endmodule

// File: tb/tb_gpio_masked_port.sv
`timescale 1ns/1ps
module tb_gpio_masked_port;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [7:0]  pwdata = '0;
  logic [7:0]  prdata, pad_out, pad_oe, sync_in;
  logic        pready;
  logic [7:0]  pad_in = 8'hA5;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  gpio_masked_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pad_in_i(pad_in), .pad_out_o(pad_out),
    .pad_oe_o(pad_oe), .sync_in_o(sync_in)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  // {write, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [28:0] VEC [NV] = '{
    {1'b0, 12'h400, 8'h00, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hA5},
    {1'b1, 12'h3FC, 8'hFF, 8'h00},
    {1'b1, 12'h400, 8'h0F, 8'h00},
    {1'b0, 12'h400, 8'h00, 8'h0F},
    {1'b0, 12'h3FC, 8'h00, 8'hA0},
    {1'b1, 12'h03C, 8'hFF, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hAF},
    {1'b1, 12'h004, 8'h00, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'hAE},
    {1'b0, 12'h004, 8'h00, 8'h00},
    {1'b0, 12'h008, 8'h00, 8'h02},
    {1'b1, 12'h400, 8'hFF, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'h0E},
    {1'b1, 12'h200, 8'hFF, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'h8E},
    {1'b0, 12'h200, 8'h00, 8'h80},
    {1'b1, 12'h800, 8'hFF, 8'h00},
    {1'b0, 12'h800, 8'h00, 8'h00},
    {1'b0, 12'h400, 8'h00, 8'hFF},
    {1'b0, 12'h000, 8'h00, 8'h00},
    {1'b0, 12'h3FC, 8'h00, 8'h8E}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0, 4, 19:      return "R5 direction readback";
      1, 5:          return "R7 input pins read synchronised pad";
      7, 9, 15:      return "R3 masked data write";
      10, 11, 16:    return "R2 single-pin select";
      13:            return "R6 input-mode write discarded";
      18:            return "R8 unmapped read";
      20:            return "R4 empty mask reads zero";
      default:       return "R8 unmapped write ignored";
    endcase
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected <100000 cycles", cyc);
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] rd;
    #1;
    check("R1 pad_oe in reset", pad_oe, 8'h00);
    check("R1 pad_out in reset", pad_out, 8'h00);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 pready high", {7'd0, pready}, 8'h01);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][28]) bus_wr(VEC[i][27:16], VEC[i][15:8]);
      else begin
        bus_rd(VEC[i][27:16], rd);
        check(vec_tag(i), rd, VEC[i][7:0]);
      end
    end

    check("R5 pad_oe follows direction", pad_oe, 8'hFF);
    check("R3 pad_out after masked writes", pad_out, 8'h8E);

    // Offset 0x401 is not the direction register
    bus_wr(12'h401, 8'h00);
    check("R8 write at 0x401 ignored", pad_oe, 8'hFF);

    // Read transfer to data window with pwdata set must not write
    @(negedge clk); psel = 1; pwrite = 0; paddr = 12'h3FC; pwdata = 8'h00;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0;
    check("R9 read does not write", pad_out, 8'h8E);

    // Setup-phase only (no penable) must not write
    @(negedge clk); psel = 1; pwrite = 1; paddr = 12'h3FC; pwdata = 8'h00;
    @(negedge clk); psel = 0; pwrite = 0;
    check("R9 setup phase alone does not write", pad_out, 8'h8E);

    // Synchroniser latency on input pins
    bus_wr(12'h400, 8'h00);
    @(negedge clk); pad_in = 8'h3C;
    @(negedge clk);
    check("R7 sync after one edge still old", sync_in, 8'hA5);
    @(negedge clk);
    check("R7 sync after two edges", sync_in, 8'h3C);
    bus_rd(12'h3FC, rd);
    check("R7 data read of input pins", rd, 8'h3C);
    check("R6 output value kept while input", pad_out, 8'h8E);

    // Asynchronous reset mid-run
    @(negedge clk); rst_ni = 1'b0;
    #1;
    check("R1 pad_out after reset", pad_out, 8'h00);
    check("R1 pad_oe after reset", pad_oe, 8'h00);
    @(negedge clk); rst_ni = 1'b1;
    bus_rd(12'h400, rd);
    check("R1 direction after reset", rd, 8'h00);

    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule